// File: doc/BRIEF.md
# LCD Controller Register Interface

This block holds the software-visible register set of a colour LCD controller. A host reaches it over a simple single-cycle bus with byte addresses inside a 4 KB window. The block stores four display timing words, the upper and lower frame base addresses and a control word. It also holds the interrupt enable mask and the raw interrupt status, and it answers a fixed set of identification bytes. Accesses that land in the palette window are not decoded here. They go out on a separate port to whatever palette storage sits next to it, and that storage's read data comes back through the bus read path.

From the register contents, the block derives the panel size in pixels and lines, the pixel depth code, the colour-order and endianness flags, and a display-active flag. A single-cycle frame tick from the video timing logic sets two status bits while the display is active. One level interrupt reports any status bit that the mask lets through. A parameter picks one of two register layouts, which differ in where the mask and control words sit and in the identification bytes returned.

Top module: `lcdc_regs`

## Requirements
- R1: After reset every register reads zero. The decoded width is then 16 pixels, the height is 1 line, and irq is low. Word indices 0 to 3 (byte offset >> 2) read back the timing words as written, index 4 the upper base and index 5 the lower base. upper_base and lower_base carry the stored values.
- R2: With LATER_MAP=0 the control word is at index 6 and the mask at index 7. With LATER_MAP=1 the two are swapped: index 6 is the mask and index 7 is control.
- R3: width_px equals ((timing0 AND 0xFC) + 4) * 4.
- R4: height_ln equals (timing1 AND 0x3FF) + 1.
- R5: depth_code is control[3:1], bgr_swap is control[8], be_bytes is control[9] and be_pixels is control[10].
- R6: disp_active is high only while control bit 0 and control bit 11 are both 1.
- R7: A frame_tick pulse while disp_active is high sets status bits 2 and 3 on the next clock edge. A tick while the display is inactive leaves the status unchanged.
- R8: A write to index 10 clears each status bit whose data bit is 1 and leaves the others. A tick accepted in the same cycle still sets bits 2 and 3.
- R9: irq is high exactly when (status AND mask) is nonzero. Index 8 reads the raw status and index 9 reads status AND mask.
- R10: Byte offsets 0xFE0 to 0xFFF read one identification byte per word in bits [7:0], selected by offset[4:2]. With LATER_MAP=0 the bytes are 10 11 04 00 0D F0 05 B1, and with LATER_MAP=1 they are 11 11 24 00 0D F0 05 B1.
- R11: For byte offsets 0x200 to 0x3FF, pal_sel follows bus_sel, pal_wr follows bus_wr, pal_idx is offset[8:2], pal_wdata is bus_wdata, and a read returns pal_rdata. Outside that window pal_sel is low.
- R12: Indices 10, 11 and 12 and every address not named above read zero. Writes to indices 8, 9, 11 to 15, to the palette window or to any other unnamed address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| frame_tick | input | 1 | One-cycle frame pulse |
| pal_sel | output | 1 | Palette window access strobe |
| pal_wr | output | 1 | Palette write |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | DATA_W | Palette write data |
| pal_rdata | input | DATA_W | Palette read data |
| irq | output | 1 | Level interrupt |
| disp_active | output | 1 | Enable and power both set |
| width_px | output | 11 | Decoded panel width |
| height_ln | output | 11 | Decoded panel height |
| depth_code | output | 3 | Pixel depth code |
| bgr_swap | output | 1 | Colour order flag |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| upper_base | output | DATA_W | Upper frame base |
| lower_base | output | DATA_W | Lower frame base |

## Verification
A corrupted status or mask bit shows up on irq in the same cycle it becomes wrong, and on the index 8 and 9 reads at the next access. A control word that was captured wrongly shows up at once on disp_active and the decoded flags. It shows up again one cycle after the next frame tick, because the status bits then set or fail to set. Geometry errors appear on width_px and height_ln as soon as the timing write completes. Layout errors between the two variants appear on the first read of index 6 or 7.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned WIX_W    = 4;
  localparam int unsigned PAL_IX_W = 7;
  localparam int unsigned GEO_W    = 11;

  localparam int unsigned IX_UPBASE = 4;
  localparam int unsigned IX_LPBASE = 5;
  localparam int unsigned IX_RAW    = 8;
  localparam int unsigned IX_MSKD   = 9;
  localparam int unsigned IX_CLEAR  = 10;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_BGR  = 8;
  localparam int unsigned CB_BEB  = 9;
  localparam int unsigned CB_BEP  = 10;
  localparam int unsigned CB_PWR  = 11;

  localparam int unsigned SB_NEXT = 2;
  localparam int unsigned SB_VCMP = 3;

  // pixels = (field[7:2] + 1) * 16
  function automatic logic [GEO_W-1:0] width_of(input logic [7:0] t0);
    logic [6:0] quads;
    quads = {1'b0, t0[7:2]} + 7'd1;
    return {quads, 4'b0000};
  endfunction

  function automatic logic [GEO_W-1:0] height_of(input logic [9:0] t1);
    return {1'b0, t1} + GEO_W'(1);
  endfunction

  function automatic logic [7:0] id_byte(input logic later, input logic [2:0] k);
    case (k)
      3'd0:    return later ? 8'h11 : 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return later ? 8'h24 : 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
  import lcdc_pkg::*;
(
  input  logic                   sel,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   in_regs,
  output logic                   in_pal,
  output logic                   in_id,
  output logic [WIX_W-1:0]       word_ix,
  output logic [2:0]             id_ix,
  output logic [PAL_IX_W-1:0]    pal_ix,
  output logic [(1<<WIX_W)-1:0]  wr_vec
);
  localparam int unsigned NREG = 1 << WIX_W;

  logic unused_lo;
  assign unused_lo = ^addr[1:0];

  assign in_regs = (addr[ADDR_W-1:WIX_W+2] == '0);
  assign in_pal  = (addr[ADDR_W-1:9] == 3'b001);
  assign in_id   = (addr[ADDR_W-1:5] == '1);
  assign word_ix = addr[WIX_W+1:2];
  assign id_ix   = addr[4:2];
  assign pal_ix  = addr[8:2];

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign wr_vec[i] = sel && wr && in_regs && (word_ix == WIX_W'(i));
  end
endmodule

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [5:0]             we_low,
  input  logic                   ctrl_we,
  input  logic [DATA_W-1:0]      wdata,
  output logic [3:0][DATA_W-1:0] timing,
  output logic [DATA_W-1:0]      upbase,
  output logic [DATA_W-1:0]      lpbase,
  output logic [DATA_W-1:0]      ctrl,
  output logic                   active
);
  for (genvar t = 0; t < 4; t++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rst_n)        timing[t] <= '0;
      else if (we_low[t]) timing[t] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upbase <= '0;
      lpbase <= '0;
      ctrl   <= '0;
    end else begin
      if (we_low[IX_UPBASE]) upbase <= wdata;
      if (we_low[IX_LPBASE]) lpbase <= wdata;
      if (ctrl_we)           ctrl   <= wdata;
    end
  end

  assign active = ctrl[CB_EN] && ctrl[CB_PWR];
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl
  import lcdc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_take,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic [DATA_W-1:0] status_nxt;

  always_comb begin
    status_nxt = status;
    if (clr_we) status_nxt = status_nxt & ~wdata;
    if (tick_take) begin
      status_nxt[SB_NEXT] = 1'b1;
      status_nxt[SB_VCMP] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '0;
      status <= '0;
    end else begin
      if (mask_we) mask <= wdata;
      status <= status_nxt;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter bit          LATER_MAP = 1'b0,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                frame_tick,
  output logic                pal_sel,
  output logic                pal_wr,
  output logic [PAL_IX_W-1:0] pal_idx,
  output logic [DATA_W-1:0]   pal_wdata,
  input  logic [DATA_W-1:0]   pal_rdata,
  output logic                irq,
  output logic                disp_active,
  output logic [GEO_W-1:0]    width_px,
  output logic [GEO_W-1:0]    height_ln,
  output logic [2:0]          depth_code,
  output logic                bgr_swap,
  output logic                be_bytes,
  output logic                be_pixels,
  output logic [DATA_W-1:0]   upper_base,
  output logic [DATA_W-1:0]   lower_base
);
  localparam int unsigned CTRL_IX = LATER_MAP ? 7 : 6;
  localparam int unsigned MASK_IX = LATER_MAP ? 6 : 7;
  localparam int unsigned NREG    = 1 << WIX_W;

  logic                   in_regs, in_pal, in_id;
  logic [WIX_W-1:0]       word_ix;
  logic [2:0]             id_ix;
  logic [NREG-1:0]        wr_vec;
  logic [3:0][DATA_W-1:0] timing;
  logic [DATA_W-1:0]      ctrl_q, mask_q, status_q;

  // Named events for the checker
  logic tick_take, ctrl_we, mask_we, clr_we, id_rd;

  lcdc_addr_dec u_dec (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .in_regs (in_regs),
    .in_pal  (in_pal),
    .in_id   (in_id),
    .word_ix (word_ix),
    .id_ix   (id_ix),
    .pal_ix  (pal_idx),
    .wr_vec  (wr_vec)
  );

  assign ctrl_we   = wr_vec[CTRL_IX];
  assign mask_we   = wr_vec[MASK_IX];
  assign clr_we    = wr_vec[IX_CLEAR];
  assign tick_take = frame_tick && disp_active;
  assign id_rd     = bus_sel && !bus_wr && in_id;

  logic unused_we;
  assign unused_we = ^{wr_vec[NREG-1:IX_CLEAR+1], wr_vec[IX_MSKD:IX_RAW]};

  lcdc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_low  (wr_vec[5:0]),
    .ctrl_we (ctrl_we),
    .wdata   (bus_wdata),
    .timing  (timing),
    .upbase  (upper_base),
    .lpbase  (lower_base),
    .ctrl    (ctrl_q),
    .active  (disp_active)
  );

  lcdc_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_take (tick_take),
    .mask_we   (mask_we),
    .clr_we    (clr_we),
    .wdata     (bus_wdata),
    .mask      (mask_q),
    .status    (status_q),
    .irq       (irq)
  );

  assign width_px   = width_of(timing[0][7:0]);
  assign height_ln  = height_of(timing[1][9:0]);
  assign depth_code = ctrl_q[3:1];
  assign bgr_swap   = ctrl_q[CB_BGR];
  assign be_bytes   = ctrl_q[CB_BEB];
  assign be_pixels  = ctrl_q[CB_BEP];

  assign pal_sel   = bus_sel && in_pal;
  assign pal_wr    = bus_wr;
  assign pal_wdata = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (in_regs) begin
      if (word_ix < WIX_W'(4))                  bus_rdata = timing[word_ix[1:0]];
      else if (word_ix == WIX_W'(IX_UPBASE))    bus_rdata = upper_base;
      else if (word_ix == WIX_W'(IX_LPBASE))    bus_rdata = lower_base;
      else if (word_ix == WIX_W'(CTRL_IX))      bus_rdata = ctrl_q;
      else if (word_ix == WIX_W'(MASK_IX))      bus_rdata = mask_q;
      else if (word_ix == WIX_W'(IX_RAW))       bus_rdata = status_q;
      else if (word_ix == WIX_W'(IX_MSKD))      bus_rdata = status_q & mask_q;
    end else if (in_pal) begin
      bus_rdata = pal_rdata;
    end else if (in_id) begin
      bus_rdata = {{(DATA_W-8){1'b0}}, id_byte(LATER_MAP, id_ix)};
    end
  end
endmodule

module lcdc_regs_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_take,
  input logic              active,
  input logic              ctrl_we,
  input logic              clr_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] mask,
  input logic              irq,
  input logic              id_rd,
  input logic [DATA_W-1:0] rdata
);
  AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_take |=> (status[3:2] == 2'b11)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr_we) |=> $stable(status)); // R7
  AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !tick_take) |=> ((status & $past(bus_wdata)) == '0)); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |-> !irq); // R9
  AST_ACTIVE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(ctrl_we)); // R6
  AST_ID_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |-> (rdata[DATA_W-1:8] == '0)); // R10
endmodule

bind lcdc_regs lcdc_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_take (tick_take),
  .active    (disp_active),
  .ctrl_we   (ctrl_we),
  .clr_we    (clr_we),
  .bus_wdata (bus_wdata),
  .status    (status_q),
  .mask      (mask_q),
  .irq       (irq),
  .id_rd     (id_rd),
  .rdata     (bus_rdata)
);

// File: tb/lcdc_regs_tb.sv
module lcdc_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, tick = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_b, pal_wd, pal_wd_b, pal_rd, pal_rd_b;
  logic        pal_sel, pal_wr, pal_sel_b, pal_wr_b;
  logic [6:0]  pal_idx, pal_idx_b;
  logic        irq, act, bgr, beb, bep, irq_b, act_b, bgr_b, beb_b, bep_b;
  logic [10:0] wid, hgt, wid_b, hgt_b;
  logic [2:0]  dep, dep_b;
  logic [31:0] upb, lpb, upb_b, lpb_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign pal_rd   = 32'hC0DE_0000 | {25'd0, pal_idx};
  assign pal_rd_b = 32'hBEEF_0000 | {25'd0, pal_idx_b};

  lcdc_regs #(.LATER_MAP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .frame_tick(tick),
    .pal_sel(pal_sel), .pal_wr(pal_wr), .pal_idx(pal_idx), .pal_wdata(pal_wd),
    .pal_rdata(pal_rd), .irq(irq), .disp_active(act), .width_px(wid),
    .height_ln(hgt), .depth_code(dep), .bgr_swap(bgr), .be_bytes(beb),
    .be_pixels(bep), .upper_base(upb), .lower_base(lpb));

  lcdc_regs #(.LATER_MAP(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .frame_tick(tick),
    .pal_sel(pal_sel_b), .pal_wr(pal_wr_b), .pal_idx(pal_idx_b), .pal_wdata(pal_wd_b),
    .pal_rdata(pal_rd_b), .irq(irq_b), .disp_active(act_b), .width_px(wid_b),
    .height_ln(hgt_b), .depth_code(dep_b), .bgr_swap(bgr_b), .be_bytes(beb_b),
    .be_pixels(bep_b), .upper_base(upb_b), .lower_base(lpb_b));

  // Model of the LATER_MAP=0 instance
  logic [31:0] m_tim [4];
  logic [31:0] m_up, m_lp, m_ctrl, m_mask, m_stat;

  function automatic bit m_active();
    return m_ctrl[0] && m_ctrl[11];
  endfunction

  function automatic logic [31:0] exp_width(input logic [31:0] t0);
    return ((t0 & 32'hFC) + 32'd4) * 32'd4;
  endfunction

  function automatic logic [31:0] exp_height(input logic [31:0] t1);
    return (t1 & 32'h3FF) + 32'd1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a >= 12'h200 && a < 12'h400) return 32'hC0DE_0000 | 32'(a[8:2]);
    if (a >= 12'hFE0) begin
      case (a[4:2])
        0: return 32'h10; 1: return 32'h11; 2: return 32'h04; 3: return 32'h00;
        4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
      endcase
    end
    if (a >= 12'h040) return 0;
    case (a[5:2])
      0, 1, 2, 3: return m_tim[a[3:2]];
      4: return m_up;
      5: return m_lp;
      6: return m_ctrl;
      7: return m_mask;
      8: return m_stat;
      9: return m_stat & m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, input bit tk);
    bit was_act = m_active();
    if (a < 12'h040) begin
      case (a[5:2])
        0, 1, 2, 3: m_tim[a[3:2]] = d;
        4: m_up = d;
        5: m_lp = d;
        6: m_ctrl = d;
        7: m_mask = d;
        10: m_stat = m_stat & ~d;
        default: ;
      endcase
    end
    if (tk && was_act) m_stat = m_stat | 32'hC;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    sel = 0; wr = 0; tick = 0;
    model_write(a, d, tk);
  endtask

  task automatic tick_pulse();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    if (m_active()) m_stat = m_stat | 32'hC;
  endtask

  task automatic bus_read(input logic [11:0] a, input string req);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    #1;
    chk(req, rdata, exp_read(a));
    sel = 0;
  endtask

  task automatic check_outs();
    chk("R3 width", 32'(wid), exp_width(m_tim[0]));
    chk("R4 height", 32'(hgt), exp_height(m_tim[1]));
    chk("R5 flags", {25'd0, bep, beb, bgr, 1'b0, dep},
        {25'd0, m_ctrl[10], m_ctrl[9], m_ctrl[8], 1'b0, m_ctrl[3:1]});
    chk("R6 active", 32'(act), 32'(m_active()));
    chk("R9 irq", 32'(irq), 32'(|(m_stat & m_mask)));
    chk("R1 bases", upb ^ lpb, m_up ^ m_lp);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) m_tim[i] = 0;
    m_up = 0; m_lp = 0; m_ctrl = 0; m_mask = 0; m_stat = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 13; i++) bus_read(12'(i * 4), "R1 reset read");
    chk("R1 reset width", 32'(wid), 32'd16);
    chk("R1 reset height", 32'(hgt), 32'd1);
    chk("R1 reset irq", 32'(irq), 32'd0);

    // R3/R4 boundaries
    bus_write(12'h000, 32'hFFFF_FFFF, 0);
    chk("R3 max width", 32'(wid), 32'd1024);
    bus_write(12'h004, 32'hFFFF_FC00, 0);
    chk("R4 min height", 32'(hgt), 32'd1);
    bus_write(12'h004, 32'h0000_03FF, 0);
    chk("R4 max height", 32'(hgt), 32'd1024);
    bus_write(12'h000, 32'h0000_0003, 0);
    chk("R3 low bits ignored", 32'(wid), 32'd16);

    // R6 enable alone, power alone, then both; R7 ignored while inactive
    bus_write(12'h01C, 32'h0000_000C, 0);
    bus_write(12'h018, 32'h0000_0001, 0);
    chk("R6 enable only", 32'(act), 0);
    tick_pulse();
    bus_read(12'h020, "R7 tick ignored inactive");
    bus_write(12'h018, 32'h0000_0800, 0);
    chk("R6 power only", 32'(act), 0);
    bus_write(12'h018, 32'h0000_0F0B, 0);
    chk("R6 both bits", 32'(act), 1);
    check_outs();
    tick_pulse();
    bus_read(12'h020, "R7 tick sets status");
    chk("R9 irq after tick", 32'(irq), 1);
    bus_read(12'h024, "R9 masked status");

    // R8 partial clear, then clear with simultaneous tick
    bus_write(12'h028, 32'h0000_0004, 0);
    bus_read(12'h020, "R8 partial clear");
    bus_write(12'h028, 32'hFFFF_FFFF, 1);
    bus_read(12'h020, "R8 tick wins over clear");
    bus_write(12'h028, 32'hFFFF_FFFF, 0);
    chk("R9 irq low after clear", 32'(irq), 0);

    // R10 ID bytes, R12 current-address and undefined reads
    for (int i = 0; i < 8; i++) bus_read(12'hFE0 + 12'(i * 4), "R10 id byte");
    bus_read(12'h02C, "R12 current upper reads zero");
    bus_read(12'h030, "R12 current lower reads zero");
    bus_read(12'h100, "R12 undefined reads zero");

    // R11 palette pass-through
    @(negedge clk);
    sel = 1; wr = 1; addr = 12'h2F4; wdata = 32'h1234_5678;
    #1;
    chk("R11 pal_sel", 32'(pal_sel), 1);
    chk("R11 pal_idx", 32'(pal_idx), 32'h3D);
    chk("R11 pal_wr", 32'(pal_wr), 1);
    chk("R11 pal_wdata", pal_wd, 32'h1234_5678);
    sel = 0; wr = 0;
    bus_read(12'h3FC, "R11 pal read");
    @(negedge clk);
    sel = 1; addr = 12'h400; #1;
    chk("R11 pal_sel outside", 32'(pal_sel), 0);
    sel = 0;

    // R12 writes to read-only / undefined indices leave state
    bus_write(12'h020, 32'hFFFF_FFFF, 0);
    bus_write(12'h024, 32'hFFFF_FFFF, 0);
    bus_write(12'h03C, 32'hFFFF_FFFF, 0);
    bus_write(12'h800, 32'hFFFF_FFFF, 0);
    for (int i = 0; i < 13; i++) bus_read(12'(i * 4), "R12 no side effect");
    check_outs();

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 5);
      logic [11:0] a;
      logic [31:0] d = $urandom;
      case (op)
        0: begin
          a = 12'(($urandom % 16) * 4);
          if (a == 12'h018 && ($urandom % 2) == 1) d = d | 32'h801;
          bus_write(a, d, bit'($urandom % 3 == 0));
        end
        1: tick_pulse();
        2: bus_read(12'(($urandom % 16) * 4), "R1 R2 R9 R12 random read");
        3: bus_write(12'h028, d, bit'($urandom % 2));
        default: bus_write(12'($urandom % 4096) & 12'hFFC, d, 0);
      endcase
      check_outs();
    end

    // R2 swapped layout on the second instance
    bus_write(12'h018, 32'h0000_000C, 0);
    bus_write(12'h01C, 32'h0000_080D, 0);
    @(negedge clk);
    sel = 1; addr = 12'h018; #1;
    chk("R2 later map idx6 is mask", rdata_b, 32'h0000_000C);
    addr = 12'h01C; #1;
    chk("R2 later map idx7 is control", rdata_b, 32'h0000_080D);
    sel = 0;
    chk("R2 later map depth", 32'(dep_b), 32'd6);
    chk("R2 later map active", 32'(act_b), 1);
    bus_read(12'h018, "R2 early map idx6 is control");
    @(negedge clk);
    sel = 1; addr = 12'hFE0; #1;
    chk("R10 later id0", rdata_b, 32'h11);
    addr = 12'hFE8; #1;
    chk("R10 later id2", rdata_b, 32'h24);
    sel = 0;

    done = 1;
    report();
  end
endmodule